// File: doc/BRIEF.md
# PCIe Link Power-Down Sequencer

This block sits on the controller side of a PCIe port. It runs the orderly shutdown of the downstream component before that component's main power is removed. A suspend request makes the block ask the link layer to transmit a PME_Turn_Off message. It does this whatever state the link appears to be in, because a link-up check could go stale before the message leaves.

If the link had trained when the request arrived, the block then watches the LTSSM state code until it shows the L2 idle code. That code means both ends have disposed of any TLPs already scheduled. A cycle-counted settling window of at least 100 ns follows. Then the reference clock enable drops, and one cycle later the main power enable drops, together with a one-cycle done pulse. If the link was not trained, the L2 wait is skipped. A wait that never ends is cut short by a timeout that raises an error flag and leaves power applied. A resume input returns the block to idle with clock and power enabled again.

States: `PD_IDLE` (waiting), `PD_SEND` (message requested), `PD_WAIT` (waiting for L2 idle), `PD_SETTLE` (timed delay), `PD_CLKOFF` (clock cut), `PD_PWROFF` (power cut, done pulse), `PD_OFF` (powered down), `PD_FAULT` (timeout). The transitions are:

- IDLE→SEND on a request.
- SEND→WAIT on acknowledge if the link was trained.
- SEND→SETTLE on acknowledge if it was not.
- WAIT→SETTLE on the L2 idle code.
- WAIT→FAULT on timeout.
- SETTLE→CLKOFF when the delay is complete.
- CLKOFF→PWROFF, then PWROFF→OFF, unconditionally.
- Any state other than IDLE→IDLE on resume.

Top module: `pcie_pwrdn_seq`

## Requirements
- R1: After reset, refclk_en and mainpwr_en are 1, and msg_req, susp_done and seq_err are 0.
- R2: susp_req sampled high in idle raises msg_req on the next cycle, whatever the LTSSM code is. msg_req stays high until msg_ack is sampled high.
- R3: The link counts as trained when the LTSSM code is greater than the detect-active code 0x01 (detect quiet is 0x00). The pre-detect-quiet code 0x05 therefore counts as trained. If the link is trained at the request, the block waits after msg_ack until the L2 idle code 0x15 is sampled.
- R4: If the link is not trained at the request, the block proceeds straight from msg_ack to the settling delay.
- R5: If 0x15 is not sampled within WAIT_LIMIT_CYC cycles of the wait, seq_err rises and stays high, and both enables stay 1 until resume.
- R6: refclk_en falls exactly SETTLE_CYC = ceil(SETTLE_MIN_PS / CLK_PERIOD_PS) cycles after the edge that leaves the wait or the message state (25 cycles, 100 ns, by default).
- R7: mainpwr_en falls one cycle after refclk_en. susp_done is a single-cycle pulse in that same cycle.
- R8: susp_req is ignored in every state but idle, including after power-down and after a fault.
- R9: resume sampled high in any state but idle returns the block to idle on the next cycle, with both enables 1 and seq_err 0.
- R10: msg_ack has no effect outside the message state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| susp_req | input | 1 | Suspend request, sampled in idle |
| resume | input | 1 | Return to idle and re-enable clock and power |
| ltssm_state | input | LW | Current LTSSM state code |
| msg_ack | input | 1 | Link layer has taken the PME_Turn_Off request |
| msg_req | output | 1 | Request to transmit PME_Turn_Off |
| refclk_en | output | 1 | Reference clock enable |
| mainpwr_en | output | 1 | Main power enable |
| susp_done | output | 1 | One-cycle pulse when both enables are off |
| seq_err | output | 1 | L2 wait timed out |

## Verification
On every cycle the assertions check four things:

- msg_req holds until it is acknowledged.
- Power is never off while the clock is on.
- susp_done coincides with the fall of main power and lasts one cycle.
- A fault, or a resume, leaves both enables on.

The exact length of the settling delay and of the timeout, the skipping of the L2 wait when the link is untrained, and the treatment of code 0x05 as trained can only be shown by the bench's scenarios. So can the ignoring of stray requests and acknowledges. There, a behavioural model is compared with the outputs cycle by cycle, and the edge counts are measured.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [2:0] {
        PD_IDLE,
        PD_SEND,
        PD_WAIT,
        PD_SETTLE,
        PD_CLKOFF,
        PD_PWROFF,
        PD_OFF,
        PD_FAULT
    } pd_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pwrdn_link_eval.sv
module pwrdn_link_eval #(
    parameter int                LW              = 6,
    parameter logic [LW-1:0]     DETECT_ACT_CODE = 6'h01,
    parameter logic [LW-1:0]     L2_IDLE_CODE    = 6'h15
) (
    input  logic [LW-1:0] ltssm_state,
    output logic          trained,
    output logic          l2_ready
);

    // Any code above detect-active means the link trained at some point,
    // including the pre-detect-quiet code taken after a trained link drops.
    always_comb begin
        trained  = (ltssm_state > DETECT_ACT_CODE);
        l2_ready = (ltssm_state == L2_IDLE_CODE);
    end

endmodule

// File: rtl/pwrdn_cycle_timer.sv
module pwrdn_cycle_timer #(
    parameter int LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic hit
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts while the owning state is active; hit marks its final cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == LAST);

endmodule

// File: rtl/pcie_pwrdn_seq.sv
module pcie_pwrdn_seq
    import pwrdn_pkg::*;
#(
    parameter int            CLK_PERIOD_PS   = 4000,
    parameter int            SETTLE_MIN_PS   = 100000,
    parameter int            WAIT_LIMIT_CYC  = 64,
    parameter int            LW              = 6,
    parameter logic [LW-1:0] DETECT_ACT_CODE = 6'h01,
    parameter logic [LW-1:0] L2_IDLE_CODE    = 6'h15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          susp_req,
    input  logic          resume,
    input  logic [LW-1:0] ltssm_state,
    input  logic          msg_ack,
    output logic          msg_req,
    output logic          refclk_en,
    output logic          mainpwr_en,
    output logic          susp_done,
    output logic          seq_err
);

    localparam int SETTLE_CYC = ceil_div(SETTLE_MIN_PS, CLK_PERIOD_PS);

    pd_state_e state, state_nx;
    logic      was_trained;
    logic      trained, l2_ready;
    logic      settle_hit, wait_hit;

    pwrdn_link_eval #(
        .LW              (LW),
        .DETECT_ACT_CODE (DETECT_ACT_CODE),
        .L2_IDLE_CODE    (L2_IDLE_CODE)
    ) u_link (
        .ltssm_state (ltssm_state),
        .trained     (trained),
        .l2_ready    (l2_ready)
    );

    pwrdn_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != PD_SETTLE),
        .hit   (settle_hit)
    );

    pwrdn_cycle_timer #(.LIMIT(WAIT_LIMIT_CYC)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != PD_WAIT),
        .hit   (wait_hit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (resume && state != PD_IDLE) begin
            state_nx = PD_IDLE;
        end else begin
            unique case (state)
                PD_IDLE:    if (susp_req) state_nx = PD_SEND;
                PD_SEND:    if (msg_ack) state_nx = was_trained ? PD_WAIT : PD_SETTLE;
                PD_WAIT: begin
                    if (l2_ready)      state_nx = PD_SETTLE;
                    else if (wait_hit) state_nx = PD_FAULT;
                end
                PD_SETTLE:  if (settle_hit) state_nx = PD_CLKOFF;
                PD_CLKOFF:  state_nx = PD_PWROFF;
                PD_PWROFF:  state_nx = PD_OFF;
                PD_OFF:     state_nx = PD_OFF;
                PD_FAULT:   state_nx = PD_FAULT;
                default:    state_nx = PD_IDLE;
            endcase
        end
    end

    // State register and the link-trained capture at request time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= PD_IDLE;
            was_trained <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == PD_IDLE && susp_req)
                was_trained <= trained;
        end
    end

    // Moore outputs
    always_comb begin
        msg_req    = 1'b0;
        refclk_en  = 1'b1;
        mainpwr_en = 1'b1;
        susp_done  = 1'b0;
        seq_err    = 1'b0;
        unique case (state)
            PD_SEND:   msg_req = 1'b1;
            PD_CLKOFF: refclk_en = 1'b0;
            PD_PWROFF: begin
                refclk_en  = 1'b0;
                mainpwr_en = 1'b0;
                susp_done  = 1'b1;
            end
            PD_OFF: begin
                refclk_en  = 1'b0;
                mainpwr_en = 1'b0;
            end
            PD_FAULT:  seq_err = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic resume,
    input logic msg_ack,
    input logic msg_req,
    input logic refclk_en,
    input logic mainpwr_en,
    input logic susp_done,
    input logic seq_err
);

    a_r2_msg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack && !resume) |=> msg_req);

    a_r7_clk_before_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        !mainpwr_en |-> !refclk_en);

    a_r7_done_at_pwr_fall: assert property (@(posedge clk) disable iff (!rst_n)
        susp_done |-> ($fell(mainpwr_en) && !$past(refclk_en)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        susp_done |=> !susp_done);

    a_r5_fault_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (refclk_en && mainpwr_en));

    a_r9_resume_restores: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (refclk_en && mainpwr_en && !seq_err && !msg_req));

    a_r2_power_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (refclk_en && mainpwr_en));

endmodule

bind pcie_pwrdn_seq pwrdn_seq_chk u_chk (.*);

// File: tb/pcie_pwrdn_seq_test.sv
module pcie_pwrdn_seq_test;

    localparam int CLK_NS  = 4;
    localparam int SETTLE  = 25;
    localparam int TIMEOUT = 64;
    localparam int WD_MAX  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       susp_req = 1'b0, resume = 1'b0, msg_ack = 1'b0;
    logic [5:0] ltssm_state = 6'h11;
    logic       msg_req, refclk_en, mainpwr_en, susp_done, seq_err;

    pcie_pwrdn_seq uut (
        .clk(clk), .rst_n(rst_n), .susp_req(susp_req), .resume(resume),
        .ltssm_state(ltssm_state), .msg_ack(msg_ack), .msg_req(msg_req),
        .refclk_en(refclk_en), .mainpwr_en(mainpwr_en),
        .susp_done(susp_done), .seq_err(seq_err)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    // Reference model: 0 idle,1 send,2 wait,3 settle,4 clk off,5 pwr off,6 off,7 fault
    int ph = 0, cnt = 0;
    bit trn = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic model_step();
        if (resume && ph != 0) ph = 0;
        else case (ph)
            0: if (susp_req) begin ph = 1; trn = (ltssm_state > 6'h01); end
            1: if (msg_ack) begin ph = trn ? 2 : 3; cnt = 0; end
            2: if (ltssm_state == 6'h15) begin ph = 3; cnt = 0; end
               else if (cnt == TIMEOUT - 1) ph = 7;
               else cnt++;
            3: if (cnt == SETTLE - 1) ph = 4; else cnt++;
            4: ph = 5;
            5: ph = 6;
            default: ;
        endcase
    endtask

    task automatic compare();
        chk(msg_req == (ph == 1), "R2 msg_req", msg_req, ph == 1);
        chk(refclk_en == (ph < 4 || ph == 7), "R6 refclk_en", refclk_en, ph < 4 || ph == 7);
        chk(mainpwr_en == (ph < 5 || ph == 7), "R7 mainpwr_en", mainpwr_en, ph < 5 || ph == 7);
        chk(susp_done == (ph == 5), "R7 susp_done", susp_done, ph == 5);
        chk(seq_err == (ph == 7), "R5 seq_err", seq_err, ph == 7);
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        model_step();
        compare();
        susp_req = 1'b0;
        msg_ack  = 1'b0;
        resume   = 1'b0;
        if (cyc > WD_MAX) begin
            chk(1'b0, "watchdog", cyc, WD_MAX);
            finish_run();
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wait_clk_low(output int at);
        at = -1;
        for (int i = 0; i < 200 && at < 0; i++) begin
            cycle();
            if (!refclk_en) at = cyc;
        end
    endtask

    task automatic do_resume();
        resume = 1'b1;
        cycle();
        chk(refclk_en && mainpwr_en && !seq_err, "R9 resume to idle", {refclk_en, mainpwr_en, seq_err}, 3'b110);
    endtask

    int e0, e1;

    initial begin
        run(3);
        @(negedge clk);
        rst_n = 1'b1;
        chk(refclk_en && mainpwr_en && !msg_req && !susp_done && !seq_err,
            "R1 reset state", {refclk_en, mainpwr_en, msg_req, susp_done, seq_err}, 5'b11000);
        run(2);

        // Trained link: request, late ack, L2 wait, settle, cut.
        ltssm_state = 6'h11;
        susp_req = 1'b1;
        cycle();
        chk(msg_req == 1'b1, "R2 request raises msg_req", msg_req, 1);
        run(3);
        chk(msg_req == 1'b1, "R2 msg_req held until ack", msg_req, 1);
        msg_ack = 1'b1;
        cycle();
        susp_req = 1'b1;
        cycle();
        msg_ack = 1'b1;
        cycle();
        run(5);
        chk(refclk_en && !msg_req, "R8 R10 stray req/ack ignored in wait", {refclk_en, msg_req}, 2'b10);
        ltssm_state = 6'h15;
        e0 = cyc + 1;
        wait_clk_low(e1);
        chk(e1 - e0 == SETTLE, "R6 settle length", e1 - e0, SETTLE);
        cycle();
        chk(!mainpwr_en && susp_done, "R7 power cut after clock", {mainpwr_en, susp_done}, 2'b01);
        susp_req = 1'b1;
        cycle();
        run(3);
        chk(!mainpwr_en && !msg_req && !susp_done, "R8 request ignored when off",
            {mainpwr_en, msg_req, susp_done}, 0);
        do_resume();

        // Untrained (detect active): message sent anyway, wait skipped.
        ltssm_state = 6'h01;
        susp_req = 1'b1;
        cycle();
        chk(msg_req == 1'b1, "R2 message sent with link down", msg_req, 1);
        msg_ack = 1'b1;
        e0 = cyc + 1;
        wait_clk_low(e1);
        chk(e1 - e0 == SETTLE, "R4 wait skipped, detect active", e1 - e0, SETTLE);
        run(3);
        do_resume();

        // Detect quiet also untrained.
        ltssm_state = 6'h00;
        susp_req = 1'b1;
        cycle();
        msg_ack = 1'b1;
        e0 = cyc + 1;
        wait_clk_low(e1);
        chk(e1 - e0 == SETTLE, "R4 wait skipped, detect quiet", e1 - e0, SETTLE);
        run(2);
        do_resume();

        // Pre-detect-quiet counts as trained: must wait for L2.
        ltssm_state = 6'h05;
        susp_req = 1'b1;
        cycle();
        msg_ack = 1'b1;
        cycle();
        run(SETTLE + 10);
        chk(refclk_en == 1'b1, "R3 code 0x05 waits for L2", refclk_en, 1);
        ltssm_state = 6'h15;
        e0 = cyc + 1;
        wait_clk_low(e1);
        chk(e1 - e0 == SETTLE, "R3 L2 releases settle", e1 - e0, SETTLE);
        run(2);
        do_resume();

        // Timeout on a link that never reaches L2.
        ltssm_state = 6'h11;
        susp_req = 1'b1;
        cycle();
        msg_ack = 1'b1;
        cycle();
        e0 = cyc;
        e1 = -1;
        for (int i = 0; i < TIMEOUT + 10 && e1 < 0; i++) begin
            cycle();
            if (seq_err) e1 = cyc;
        end
        chk(e1 - e0 == TIMEOUT, "R5 timeout length", e1 - e0, TIMEOUT);
        susp_req = 1'b1;
        cycle();
        run(4);
        chk(seq_err && refclk_en && mainpwr_en && !msg_req, "R5 R8 fault holds, power on",
            {seq_err, refclk_en, mainpwr_en, msg_req}, 4'b1110);
        do_resume();

        // Resume during settle.
        ltssm_state = 6'h00;
        susp_req = 1'b1;
        cycle();
        msg_ack = 1'b1;
        cycle();
        run(10);
        do_resume();
        run(SETTLE + 5);
        chk(refclk_en && mainpwr_en, "R9 resume aborts settle", {refclk_en, mainpwr_en}, 2'b11);

        // Resume while message pending.
        susp_req = 1'b1;
        cycle();
        do_resume();
        chk(!msg_req, "R9 resume drops msg_req", msg_req, 0);
        msg_ack = 1'b1;
        cycle();
        run(3);
        chk(!msg_req && refclk_en, "R10 ack in idle ignored", {msg_req, refclk_en}, 2'b01);

        finish_run();
    end

endmodule